// File: doc/BRIEF.md
# Dual-Mode Phoneline Receive Port

This block sits between the decoder of a 1 Mb/s phoneline physical layer and the reconciliation layer of a MAC. It takes decoded receive bytes from the decoder through a valid/ready byte stream. Each byte carries a start-of-frame flag or an end-of-stream flag. The block presents the bytes on a shared set of output pins in one of two formats. In nibble mode each byte becomes two 4-bit transfers, each held for one receive clock period, with a data-valid strobe. In serial mode each byte becomes eight single-bit transfers on data bit 0, timed by the same clock pin, which then serves as the serial receive clock.

A strap input chooses the mode and is captured only while reset is high. In serial mode the data-valid pin instead carries the serial output of the management bus. Carrier sense and collision outputs are driven in both modes. The receive clock is made by dividing the system clock, and every data change lines up with a falling edge of that clock.

Top module: `rxif_rx_port`

## Requirements
- R1: With the strap captured as 0 (nibble mode), each accepted byte is sent as two transfers, bits [3:0] first and then bits [7:4], on rxd_o[3:0], one transfer per receive clock period.
- R2: With the strap captured as 1 (serial mode), each accepted byte is sent as eight transfers, bit 0 first, on rxd_o[0], while rxd_o[3:1] stay 0.
- R3: rx_clk_o has a period of 2*HALF_PER system cycles. It is low for the first HALF_PER cycles after each transfer update, and rxd_o changes only in the cycle in which rx_clk_o falls.
- R4: In nibble mode rx_dv_o is high for every transfer of the byte flagged start-of-frame and of each later byte up to the end-of-stream byte. It is low for the end-of-stream byte and for bytes outside a frame, and rxd_o is 0 whenever a transfer is not shown as valid.
- R5: In serial mode rx_dv_o follows spi_so_i in the same cycle.
- R6: crs_o equals (tx_active_i OR rx_active_i) delayed by one system cycle.
- R7: col_o equals col_det_i delayed by one system cycle, in both modes.
- R8: mode_sel_i is captured only while rst is high. Changing it afterwards does not alter the output format until the next reset.
- R9: in_ready_o is high for one cycle at an update only when all transfers of the previous byte have been sent. A byte is taken when in_valid_i and in_ready_o are both high, and its first transfer appears in the next cycle. An update with no byte offered gives a transfer of rxd_o = 0 with rx_dv_o low.
- R10: After reset, rxd_o, rx_clk_o, crs_o and col_o are 0, and rx_dv_o is 0 while spi_so_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel_i | input | 1 | Format strap: 0 nibble, 1 serial; captured during reset |
| in_valid_i | input | 1 | Decoder byte available |
| in_byte_i | input | 8 | Decoded receive byte |
| in_sof_i | input | 1 | Byte is the start-of-frame delimiter |
| in_eos_i | input | 1 | Byte is the end-of-stream delimiter |
| in_ready_o | output | 1 | Byte taken in this cycle when valid |
| tx_active_i | input | 1 | Transmit medium busy |
| rx_active_i | input | 1 | Receive medium busy |
| col_det_i | input | 1 | Collision detected |
| spi_so_i | input | 1 | Management serial output routed in serial mode |
| rxd_o | output | 4 | Receive data pins |
| rx_clk_o | output | 1 | Receive or serial receive clock |
| rx_dv_o | output | 1 | Data valid (nibble mode) or management serial out (serial mode) |
| crs_o | output | 1 | Carrier sense |
| col_o | output | 1 | Collision |

## Verification
A byte accepted at an update edge shows its first transfer right after that edge. The bench therefore samples data at the falling system edge that follows each observed fall of rx_clk_o, and it logs acceptance at the falling edge before the update, where in_ready_o is already visible. Carrier sense and collision are registered once, so each is compared against the inputs driven two sample points earlier. The management pass-through is combinational and is compared in the same sample. The bench runs every byte value through both formats. It inserts idle updates in the middle of frames and flips the strap after reset.

// File: rtl/rxif_pkg.sv
package rxif_pkg;

    typedef enum logic {
        MODE_NIBBLE = 1'b0,
        MODE_SERIAL = 1'b1
    } rxif_mode_e;

    typedef struct packed {
        logic [3:0] data;
        logic       valid;
    } rxif_slot_t;

    localparam int LEFT_W = 4;

    function automatic logic [LEFT_W-1:0] slots_per_byte(input rxif_mode_e m);
        return (m == MODE_SERIAL) ? 4'd8 : 4'd2;
    endfunction

    function automatic logic [7:0] shift_out(input logic [7:0] b, input rxif_mode_e m);
        return (m == MODE_SERIAL) ? (b >> 1) : (b >> 4);
    endfunction

    function automatic rxif_slot_t make_slot(input logic [7:0] b, input rxif_mode_e m,
                                             input logic show);
        rxif_slot_t s;
        s.valid = show;
        if (!show)
            s.data = 4'b0000;
        else if (m == MODE_SERIAL)
            s.data = {3'b000, b[0]};
        else
            s.data = b[3:0];
        return s;
    endfunction

endpackage

// File: rtl/rxif_clkgen.sv
module rxif_clkgen #(
    parameter int HALF_PER = 4
) (
    input  logic clk,
    input  logic rst,
    output logic upd_o,
    output logic rxclk_o
);
    localparam int FULL = 2 * HALF_PER;
    localparam int CW   = (FULL > 2) ? $clog2(FULL) : 1;
    localparam logic [CW-1:0] LAST = CW'(FULL - 1);
    localparam logic [CW-1:0] MID  = CW'(HALF_PER);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign upd_o   = (cnt_q == LAST);
    assign rxclk_o = (cnt_q >= MID);
endmodule

// File: rtl/rxif_line_status.sv
module rxif_line_status (
    input  logic clk,
    input  logic rst,
    input  logic tx_active_i,
    input  logic rx_active_i,
    input  logic col_det_i,
    output logic crs_o,
    output logic col_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            crs_o <= 1'b0;
            col_o <= 1'b0;
        end else begin
            crs_o <= tx_active_i | rx_active_i;
            col_o <= col_det_i;
        end
    end
endmodule

// File: rtl/rxif_slot_engine.sv
module rxif_slot_engine
    import rxif_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rxif_mode_e mode_i,
    input  logic       upd_i,
    input  logic       in_valid_i,
    input  logic [7:0] in_byte_i,
    input  logic       in_sof_i,
    input  logic       in_eos_i,
    output logic       in_ready_o,
    output rxif_slot_t slot_o
);
    logic [7:0]        sh_q;
    logic [LEFT_W-1:0] left_q;
    logic              show_q;
    logic              frame_q;
    logic              show_new;
    logic              frame_new;

    assign in_ready_o = upd_i && (left_q == '0);
    assign show_new   = !in_eos_i && (in_sof_i || frame_q);
    assign frame_new  = in_eos_i ? 1'b0 : (in_sof_i ? 1'b1 : frame_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            left_q  <= '0;
            show_q  <= 1'b0;
            frame_q <= 1'b0;
            slot_o  <= '0;
        end else if (upd_i) begin
            if (left_q != '0) begin
                slot_o <= make_slot(sh_q, mode_i, show_q);
                sh_q   <= shift_out(sh_q, mode_i);
                left_q <= LEFT_W'(left_q - 1'b1);
            end else if (in_valid_i) begin
                slot_o  <= make_slot(in_byte_i, mode_i, show_new);
                sh_q    <= shift_out(in_byte_i, mode_i);
                left_q  <= LEFT_W'(slots_per_byte(mode_i) - 1'b1);
                show_q  <= show_new;
                frame_q <= frame_new;
            end else begin
                slot_o <= '0;
            end
        end
    end
endmodule

// File: rtl/rxif_rx_port.sv
module rxif_rx_port
    import rxif_pkg::*;
#(
    parameter int HALF_PER = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_sel_i,
    input  logic       in_valid_i,
    input  logic [7:0] in_byte_i,
    input  logic       in_sof_i,
    input  logic       in_eos_i,
    output logic       in_ready_o,
    input  logic       tx_active_i,
    input  logic       rx_active_i,
    input  logic       col_det_i,
    input  logic       spi_so_i,
    output logic [3:0] rxd_o,
    output logic       rx_clk_o,
    output logic       rx_dv_o,
    output logic       crs_o,
    output logic       col_o
);
    rxif_mode_e mode_q;
    logic       upd;
    rxif_slot_t slot;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= rxif_mode_e'(mode_sel_i);
    end

    rxif_clkgen #(.HALF_PER(HALF_PER)) u_clk (
        .clk     (clk),
        .rst     (rst),
        .upd_o   (upd),
        .rxclk_o (rx_clk_o)
    );

    rxif_slot_engine u_eng (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode_q),
        .upd_i      (upd),
        .in_valid_i (in_valid_i),
        .in_byte_i  (in_byte_i),
        .in_sof_i   (in_sof_i),
        .in_eos_i   (in_eos_i),
        .in_ready_o (in_ready_o),
        .slot_o     (slot)
    );

    rxif_line_status u_stat (
        .clk         (clk),
        .rst         (rst),
        .tx_active_i (tx_active_i),
        .rx_active_i (rx_active_i),
        .col_det_i   (col_det_i),
        .crs_o       (crs_o),
        .col_o       (col_o)
    );

    assign rxd_o   = slot.data;
    assign rx_dv_o = (mode_q == MODE_SERIAL) ? spi_so_i : slot.valid;
endmodule

// File: rtl/rxif_rx_port_chk.sv
module rxif_rx_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       mode_q,
    input logic       rx_clk_o,
    input logic [3:0] rxd_o,
    input logic       rx_dv_o,
    input logic       crs_o,
    input logic       col_o,
    input logic       in_ready_o,
    input logic       in_valid_i,
    input logic       in_eos_i,
    input logic       tx_active_i,
    input logic       rx_active_i,
    input logic       col_det_i,
    input logic       spi_so_i
);
    // R3
    data_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !($past(rx_clk_o) && !rx_clk_o) |-> $stable(rxd_o));

    // R2
    serial_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        mode_q |-> (rxd_o[3:1] == 3'b000));

    // R4
    eos_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && in_valid_i && in_ready_o && in_eos_i) |=> !rx_dv_o);

    // R5
    spi_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        mode_q |-> (rx_dv_o == spi_so_i));

    // R6
    crs_on_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_active_i || rx_active_i) |=> crs_o);

    // R6
    crs_off_chk: assert property (@(posedge clk) disable iff (rst)
        !(tx_active_i || rx_active_i) |=> !crs_o);

    // R7
    col_follow_chk: assert property (@(posedge clk) disable iff (rst)
        col_det_i |=> col_o);

    // R8
    strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(mode_q));

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready_o |=> !in_ready_o);
endmodule

bind rxif_rx_port rxif_rx_port_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_q      (mode_q),
    .rx_clk_o    (rx_clk_o),
    .rxd_o       (rxd_o),
    .rx_dv_o     (rx_dv_o),
    .crs_o       (crs_o),
    .col_o       (col_o),
    .in_ready_o  (in_ready_o),
    .in_valid_i  (in_valid_i),
    .in_eos_i    (in_eos_i),
    .tx_active_i (tx_active_i),
    .rx_active_i (rx_active_i),
    .col_det_i   (col_det_i),
    .spi_so_i    (spi_so_i)
);

// File: tb/sim_rxif_rx_port.sv
module sim_rxif_rx_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_sel_i = 1'b0;
    logic       in_valid_i = 1'b0;
    logic [7:0] in_byte_i = 8'h00;
    logic       in_sof_i = 1'b0;
    logic       in_eos_i = 1'b0;
    logic       tx_active_i = 1'b0;
    logic       rx_active_i = 1'b0;
    logic       col_det_i = 1'b0;
    logic       spi_so_i = 1'b0;
    logic       in_ready_o;
    logic [3:0] rxd_o;
    logic       rx_clk_o, rx_dv_o, crs_o, col_o;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] sb [0:1023];
    logic [1:0] sk [0:1023];   // 0 plain, 1 start, 2 end, 3 gap
    int         nstim = 0;

    logic [3:0] qd [0:4095];
    logic       qv [0:4095];
    int         qh, qt;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxif_rx_port #(.HALF_PER(HALF)) u0 (
        .clk(clk), .rst(rst), .mode_sel_i(mode_sel_i),
        .in_valid_i(in_valid_i), .in_byte_i(in_byte_i),
        .in_sof_i(in_sof_i), .in_eos_i(in_eos_i), .in_ready_o(in_ready_o),
        .tx_active_i(tx_active_i), .rx_active_i(rx_active_i),
        .col_det_i(col_det_i), .spi_so_i(spi_so_i),
        .rxd_o(rxd_o), .rx_clk_o(rx_clk_o), .rx_dv_o(rx_dv_o),
        .crs_o(crs_o), .col_o(col_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic add(input logic [7:0] b, input logic [1:0] k);
        sb[nstim] = b;
        sk[nstim] = k;
        nstim++;
    endtask

    task automatic build_stim();
        nstim = 0;
        add(8'h00, 2'd3);
        for (int i = 0; i < 3; i++) add(8'h55, 2'd0);
        add(8'hD5, 2'd1);
        for (int v = 0; v < 256; v++) begin
            add(8'(v), 2'd0);
            if (v % 50 == 49) add(8'h00, 2'd3);
        end
        add(8'hAA, 2'd2);
        add(8'h00, 2'd3);
        add(8'h00, 2'd3);
        add(8'h55, 2'd0);
        add(8'h5D, 2'd1);
        add(8'h3C, 2'd0);
        add(8'hC3, 2'd0);
        add(8'h0F, 2'd2);
        add(8'h00, 2'd3);
    endtask

    task automatic drive_item(input int si);
        if (si < nstim && sk[si] != 2'd3) begin
            in_valid_i = 1'b1;
            in_byte_i  = sb[si];
            in_sof_i   = (sk[si] == 2'd1);
            in_eos_i   = (sk[si] == 2'd2);
        end else begin
            in_valid_i = 1'b0;
            in_byte_i  = 8'h00;
            in_sof_i   = 1'b0;
            in_eos_i   = 1'b0;
        end
    endtask

    task automatic run_mode(input bit m);
        bit   bfr, prev_clk, show;
        int   last_fall, cyc, si, drain;
        logic p1c, p2c, p1l, p2l, ncrs;
        logic [3:0] ed;
        logic ev;
        mode_sel_i  = m;
        rst         = 1'b1;
        tx_active_i = 1'b0;
        rx_active_i = 1'b0;
        col_det_i   = 1'b0;
        spi_so_i    = 1'b0;
        drive_item(nstim);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk(rxd_o == 4'h0, "R10 rxd", rxd_o, 0);
        chk(rx_clk_o == 1'b0, "R10 rx_clk", rx_clk_o, 0);
        chk(rx_dv_o == 1'b0, "R10 dv", rx_dv_o, 0);
        chk(crs_o == 1'b0, "R10 crs", crs_o, 0);
        chk(col_o == 1'b0, "R10 col", col_o, 0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        mode_sel_i = !m;   // R8: strap change after reset must be ignored
        bfr = 0; prev_clk = 0; last_fall = -1; cyc = 0; si = 0; drain = 0;
        p1c = 0; p2c = 0; p1l = 0; p2l = 0;
        qh = 0; qt = 0;
        drive_item(0);
        for (int k = 0; k < 40000; k++) begin
            @(negedge clk);
            cyc++;
            if (prev_clk && !rx_clk_o) begin
                if (last_fall >= 0)
                    chk(cyc - last_fall == 2*HALF, "R3 period", cyc - last_fall, 2*HALF);
                last_fall = cyc;
                if (qh != qt) begin
                    ed = qd[qh]; ev = qv[qh]; qh++;
                end else begin
                    ed = 4'h0; ev = 1'b0;
                    if (si >= nstim) drain++;
                end
                if (m) begin
                    chk(rxd_o == ed, "R2 R8 serial data", rxd_o, ed);
                end else begin
                    chk(rxd_o == ed, "R1 R8 nibble data", rxd_o, ed);
                    chk(rx_dv_o == ev, "R4 data valid", rx_dv_o, ev);
                end
            end
            prev_clk = rx_clk_o;
            if (m) chk(rx_dv_o == spi_so_i, "R5 spi pass", rx_dv_o, spi_so_i);
            chk(crs_o == p2c, "R6 carrier", crs_o, p2c);
            chk(col_o == p2l, "R7 collision", col_o, p2l);
            if (in_ready_o && si < nstim) begin
                if (sk[si] != 2'd3) begin
                    show = (sk[si] != 2'd2) && ((sk[si] == 2'd1) || bfr);
                    if (sk[si] == 2'd1) bfr = 1;
                    if (sk[si] == 2'd2) bfr = 0;
                    if (m) begin
                        for (int b = 0; b < 8; b++) begin
                            qd[qt] = show ? {3'b000, sb[si][b]} : 4'h0;
                            qv[qt] = show; qt++;
                        end
                    end else begin
                        qd[qt] = show ? sb[si][3:0] : 4'h0; qv[qt] = show; qt++;
                        qd[qt] = show ? sb[si][7:4] : 4'h0; qv[qt] = show; qt++;
                    end
                end
                si++;
            end
            if (si >= nstim && qh == qt && drain >= 4) break;
            @(posedge clk);
            #1;
            drive_item(si);
            ncrs = k[3] | k[4];
            tx_active_i = k[3];
            rx_active_i = k[4];
            col_det_i   = k[2];
            spi_so_i    = k[1];
            p2c = p1c; p1c = ncrs;
            p2l = p1l; p1l = k[2];
        end
        // R9 every byte taken and all transfers emitted
        chk(si == nstim, "R9 bytes taken", si, nstim);
        chk(qh == qt, "R9 drained", qt - qh, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        build_stim();
        run_mode(1'b0);
        run_mode(1'b1);
        run_mode(1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule